// File: doc/BRIEF.md
# Register Map Dump Serializer

This block carries out the "dump every register" debug command. When started, it walks the peripheral register space and turns each register into bytes on a valid/ready byte stream. The space is organised as modules of 32 registers, and the walk runs from module 0 index 0 up to a last module/index pair. After the peripherals it sends a fixed list of system registers. The first byte of the stream is a header that gives how many peripheral registers follow.

Peripheral values come from a combinational read port. The block drives a module/index address, and the port returns a 16-bit value, a width flag and an "implemented" flag. A single-cycle read strobe marks the one cycle in which a register is actually sampled. Each register is read once and held while its bytes drain, so a stalled consumer never causes a second read.

Some addresses hold registers whose read has side effects. These are listed in a parameter table and are never strobed; their slot is sent as zero. System registers are reached through a select code, which picks an entry of a read mux. Each entry of the parameter list carries its own select code and width.

Top module: `regdump_ser`

## Requirements
- R1: After reset, out_valid, busy, done and pr_rd are all 0.
- R2: The first byte sent after start is 8'hAE (174), the peripheral register count.
- R3: Peripheral registers are sent in address order: index 0 to 31 within a module, then the next module, from module 0 index 0 through module 5 index 0Dh. Each is sent as two bytes, low byte first. For an implemented 16-bit register the bytes are pr_data[7:0] and then pr_data[15:8].
- R4: For an implemented peripheral register with pr_wide=0, the second byte is 8'h00 and the first is pr_data[7:0].
- R5: An address with pr_impl=0 is sent as two 8'h00 bytes, and pr_rd is never asserted there.
- R6: The protected addresses are (0,0Eh), (1,0Ah), (2,03h), (3,10h), (4,05h), (5,02h) and (5,0Ch), as (module,index). Each is sent as two 8'h00 bytes and is never strobed. pr_rd is at most one cycle long per register.
- R7: After the peripherals, system entries k = 0 to 39 are sent in order. Entry k drives sys_sel = k. It is 8 bits wide when k mod 5 is 3 or 4, and 16 bits otherwise. It is sent low byte first, and the high byte is sent only for 16-bit entries. The section totals 64 bytes.
- R8: A dump sends exactly 413 bytes. done is high for exactly one cycle, the cycle after the last byte is accepted. busy is high from the cycle after start until done.
- R9: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged.
- R10: start while busy is ignored: the running dump neither restarts nor gains extra bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a dump (taken only when idle) |
| busy | output | 1 | Dump in progress |
| done | output | 1 | One-cycle pulse after the final byte |
| pr_mod | output | 3 | Peripheral module address |
| pr_idx | output | 5 | Peripheral index within the module |
| pr_rd | output | 1 | Peripheral read strobe |
| pr_data | input | 16 | Peripheral read data |
| pr_wide | input | 1 | Peripheral register is 16 bits |
| pr_impl | input | 1 | Peripheral address is implemented |
| sys_sel | output | 6 | System register select code |
| sys_data | input | 16 | System register read data |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Consumer accepts the byte |
| out_data | output | 8 | Output byte |

## Verification
Three dumps run against the same register model, each under a different out_ready pattern. With ready held high, the order and byte values are checked at full rate. With ready alternating, a dropped or repeated high byte becomes visible. With irregular stalls, the hold-steady rule is tested and any second read of a held register is caught. In the register model, the upper byte of every value is nonzero and the implemented and width flags vary by address. A missing 8-bit zeroing, a strobe at an unimplemented or protected slot, or a wrong module wrap therefore each changes at least one expected byte.

// File: rtl/regdump_pkg.sv
package regdump_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HDR,
        ST_P_FETCH,
        ST_P_LO,
        ST_P_HI,
        ST_S_FETCH,
        ST_S_LO,
        ST_S_HI,
        ST_FIN
    } dump_st_e;

    localparam int DEF_NUM_SYS  = 40;
    localparam int DEF_SEL_W    = 6;
    localparam int DEF_NUM_MASK = 7;

    // protected (module,index) pairs, {mod[2:0], idx[4:0]} per entry
    localparam logic [DEF_NUM_MASK*8-1:0] DEF_MASK_LIST =
        {8'hAC, 8'hA2, 8'h85, 8'h70, 8'h43, 8'h2A, 8'h0E};

    function automatic logic [DEF_NUM_SYS*DEF_SEL_W-1:0] def_sys_sel();
        logic [DEF_NUM_SYS*DEF_SEL_W-1:0] r;
        r = '0;
        for (int i = 0; i < DEF_NUM_SYS; i++) begin
            r[i*DEF_SEL_W +: DEF_SEL_W] = DEF_SEL_W'(i);
        end
        return r;
    endfunction

    function automatic logic [DEF_NUM_SYS-1:0] def_sys_wide();
        logic [DEF_NUM_SYS-1:0] r;
        for (int i = 0; i < DEF_NUM_SYS; i++) begin
            r[i] = ((i % 5) < 3);
        end
        return r;
    endfunction

endpackage

// File: rtl/regdump_mask.sv
module regdump_mask #(
    parameter int MOD_W    = 3,
    parameter int IDX_W    = 5,
    parameter int NUM_MASK = 7,
    parameter logic [NUM_MASK*(MOD_W+IDX_W)-1:0] MASK_LIST = '0
) (
    input  logic [MOD_W-1:0] mod_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic             hit_o
);
    localparam int ADDR_W = MOD_W + IDX_W;

    logic [NUM_MASK-1:0] match;

    genvar g;
    generate
        for (g = 0; g < NUM_MASK; g++) begin : g_cmp
            assign match[g] = (MASK_LIST[g*ADDR_W +: ADDR_W] == {mod_i, idx_i});
        end
    endgenerate

    assign hit_o = |match;
endmodule

// File: rtl/regdump_syslist.sv
module regdump_syslist #(
    parameter int NUM_SYS = 40,
    parameter int SEL_W   = 6,
    parameter int SK_W    = 6,
    parameter logic [NUM_SYS*SEL_W-1:0] SEL_LIST  = '0,
    parameter logic [NUM_SYS-1:0]       WIDE_LIST = '0
) (
    input  logic [SK_W-1:0]  sk_i,
    output logic [SEL_W-1:0] sel_o,
    output logic             wide_o
);
    logic [SEL_W-1:0] sel_arr  [NUM_SYS];
    logic             wide_arr [NUM_SYS];

    genvar g;
    generate
        for (g = 0; g < NUM_SYS; g++) begin : g_ent
            assign sel_arr[g]  = SEL_LIST[g*SEL_W +: SEL_W];
            assign wide_arr[g] = WIDE_LIST[g];
        end
    endgenerate

    always_comb begin
        sel_o  = '0;
        wide_o = 1'b0;
        for (int i = 0; i < NUM_SYS; i++) begin
            if (sk_i == SK_W'(i)) begin
                sel_o  = sel_arr[i];
                wide_o = wide_arr[i];
            end
        end
    end
endmodule

// File: rtl/regdump_ser.sv
module regdump_ser
    import regdump_pkg::*;
#(
    parameter int MOD_W    = 3,
    parameter int IDX_W    = 5,
    parameter int LAST_MOD = 5,
    parameter int LAST_IDX = 13,
    parameter int NUM_MASK = DEF_NUM_MASK,
    parameter logic [NUM_MASK*(MOD_W+IDX_W)-1:0] MASK_LIST = DEF_MASK_LIST,
    parameter int NUM_SYS  = DEF_NUM_SYS,
    parameter int SEL_W    = DEF_SEL_W,
    parameter logic [NUM_SYS*SEL_W-1:0] SYS_SEL_LIST  = def_sys_sel(),
    parameter logic [NUM_SYS-1:0]       SYS_WIDE_LIST = def_sys_wide()
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic [MOD_W-1:0] pr_mod,
    output logic [IDX_W-1:0] pr_idx,
    output logic             pr_rd,
    input  logic [15:0]      pr_data,
    input  logic             pr_wide,
    input  logic             pr_impl,
    output logic [SEL_W-1:0] sys_sel,
    input  logic [15:0]      sys_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data
);
    localparam int NUM_PERI = LAST_MOD * (2 ** IDX_W) + LAST_IDX + 1;
    localparam logic [7:0] HDR_BYTE = 8'(NUM_PERI);
    localparam int SK_W = (NUM_SYS > 1) ? $clog2(NUM_SYS) : 1;
    localparam logic [MOD_W-1:0] MOD_END = MOD_W'(LAST_MOD);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(LAST_IDX);
    localparam logic [IDX_W-1:0] IDX_TOP = '1;
    localparam logic [SK_W-1:0]  SK_END  = SK_W'(NUM_SYS - 1);

    typedef struct packed {
        dump_st_e         st;
        logic [MOD_W-1:0] mod;
        logic [IDX_W-1:0] idx;
        logic [SK_W-1:0]  sk;
        logic [15:0]      hold;
    } dump_regs_t;

    dump_regs_t r_d, r_q;

    logic mask_hit;
    logic sys_wide;
    logic rd_ok;
    logic last_peri;
    logic last_sys;

    regdump_mask #(
        .MOD_W     (MOD_W),
        .IDX_W     (IDX_W),
        .NUM_MASK  (NUM_MASK),
        .MASK_LIST (MASK_LIST)
    ) u_mask (
        .mod_i (r_q.mod),
        .idx_i (r_q.idx),
        .hit_o (mask_hit)
    );

    regdump_syslist #(
        .NUM_SYS   (NUM_SYS),
        .SEL_W     (SEL_W),
        .SK_W      (SK_W),
        .SEL_LIST  (SYS_SEL_LIST),
        .WIDE_LIST (SYS_WIDE_LIST)
    ) u_sys (
        .sk_i   (r_q.sk),
        .sel_o  (sys_sel),
        .wide_o (sys_wide)
    );

    assign pr_mod    = r_q.mod;
    assign pr_idx    = r_q.idx;
    assign busy      = (r_q.st != ST_IDLE);
    assign rd_ok     = pr_impl && !mask_hit;
    assign last_peri = (r_q.mod == MOD_END) && (r_q.idx == IDX_END);
    assign last_sys  = (r_q.sk == SK_END);

    always_comb begin
        r_d       = r_q;
        done      = 1'b0;
        pr_rd     = 1'b0;
        out_valid = 1'b0;
        out_data  = 8'h00;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st  = ST_HDR;
                    r_d.mod = '0;
                    r_d.idx = '0;
                    r_d.sk  = '0;
                end
            end
            ST_HDR: begin
                out_valid = 1'b1;
                out_data  = HDR_BYTE;
                if (out_ready) r_d.st = ST_P_FETCH;
            end
            ST_P_FETCH: begin
                pr_rd = rd_ok;
                if (!rd_ok)       r_d.hold = 16'h0000;
                else if (pr_wide) r_d.hold = pr_data;
                else              r_d.hold = {8'h00, pr_data[7:0]};
                r_d.st = ST_P_LO;
            end
            ST_P_LO: begin
                out_valid = 1'b1;
                out_data  = r_q.hold[7:0];
                if (out_ready) r_d.st = ST_P_HI;
            end
            ST_P_HI: begin
                out_valid = 1'b1;
                out_data  = r_q.hold[15:8];
                if (out_ready) begin
                    if (last_peri) begin
                        r_d.st = ST_S_FETCH;
                        r_d.sk = '0;
                    end else begin
                        r_d.st  = ST_P_FETCH;
                        r_d.idx = r_q.idx + 1'b1;
                        if (r_q.idx == IDX_TOP) r_d.mod = r_q.mod + 1'b1;
                    end
                end
            end
            ST_S_FETCH: begin
                r_d.hold = sys_wide ? sys_data : {8'h00, sys_data[7:0]};
                r_d.st   = ST_S_LO;
            end
            ST_S_LO: begin
                out_valid = 1'b1;
                out_data  = r_q.hold[7:0];
                if (out_ready) begin
                    if (sys_wide) begin
                        r_d.st = ST_S_HI;
                    end else if (last_sys) begin
                        r_d.st = ST_FIN;
                    end else begin
                        r_d.st = ST_S_FETCH;
                        r_d.sk = r_q.sk + 1'b1;
                    end
                end
            end
            ST_S_HI: begin
                out_valid = 1'b1;
                out_data  = r_q.hold[15:8];
                if (out_ready) begin
                    if (last_sys) begin
                        r_d.st = ST_FIN;
                    end else begin
                        r_d.st = ST_S_FETCH;
                        r_d.sk = r_q.sk + 1'b1;
                    end
                end
            end
            ST_FIN: begin
                done   = 1'b1;
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.mod  <= '0;
            r_q.idx  <= '0;
            r_q.sk   <= '0;
            r_q.hold <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/regdump_ser_chk.sv
module regdump_ser_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       pr_rd,
    input logic       pr_impl,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data
);
    // R2
    header_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (out_valid && out_data == 8'hAE));

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!out_valid && busy));

    // R6
    single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pr_rd |=> !pr_rd);

    // R5
    read_impl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pr_rd |-> pr_impl);
endmodule

bind regdump_ser regdump_ser_chk u_regdump_ser_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .pr_rd     (pr_rd),
    .pr_impl   (pr_impl),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/regdump_ser_bench.sv
module regdump_ser_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        busy, done, pr_rd, out_valid;
    logic [2:0]  pr_mod;
    logic [4:0]  pr_idx;
    logic [15:0] pr_data, sys_data;
    logic        pr_wide, pr_impl;
    logic [5:0]  sys_sel;
    logic        out_ready = 1'b0;
    logic [7:0]  out_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int mode = 0;
    int bytes_seen = 0;
    int dumps_done = 0;
    logic [7:0] exp_q[$];
    logic       prev_stall = 1'b0;
    logic [7:0] prev_data = 8'h00;
    logic       prev_rd = 1'b0;

    always #2 clk = ~clk;

    // register model
    function automatic logic m_impl(int m, int i);
        return ((m * 32 + i) % 7) != 3;
    endfunction
    function automatic logic m_wide(int m, int i);
        return (i % 3) != 0;
    endfunction
    function automatic logic [15:0] m_val(int m, int i);
        return {8'(64 + m * 16 + i), 8'(i * 7 + m + 1)};
    endfunction
    function automatic logic m_prot(int m, int i);
        int pm[7] = '{0, 1, 2, 3, 4, 5, 5};
        int pi[7] = '{14, 10, 3, 16, 5, 2, 12};
        for (int j = 0; j < 7; j++) if (pm[j] == m && pi[j] == i) return 1'b1;
        return 1'b0;
    endfunction
    function automatic logic [15:0] s_val(int k);
        return {8'(k * 3 + 17), 8'(255 - k)};
    endfunction

    assign pr_impl  = m_impl(int'(pr_mod), int'(pr_idx));
    assign pr_wide  = m_wide(int'(pr_mod), int'(pr_idx));
    assign pr_data  = m_val(int'(pr_mod), int'(pr_idx));
    assign sys_data = s_val(int'(sys_sel));

    regdump_ser u_regdump_ser (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .pr_mod(pr_mod), .pr_idx(pr_idx), .pr_rd(pr_rd), .pr_data(pr_data),
        .pr_wide(pr_wide), .pr_impl(pr_impl), .sys_sel(sys_sel),
        .sys_data(sys_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic build_expected();
        exp_q.push_back(8'hAE); // R2
        for (int m = 0; m <= 5; m++) begin
            for (int i = 0; i < 32; i++) begin
                logic [15:0] v;
                if (m == 5 && i > 13) break;
                if (!m_impl(m, i) || m_prot(m, i)) v = 16'h0000;    // R5 R6
                else if (!m_wide(m, i))           v = {8'h00, m_val(m, i)[7:0]}; // R4
                else                              v = m_val(m, i);  // R3
                exp_q.push_back(v[7:0]);
                exp_q.push_back(v[15:8]);
            end
        end
        for (int k = 0; k < 40; k++) begin // R7
            exp_q.push_back(s_val(k)[7:0]);
            if ((k % 5) < 3) exp_q.push_back(s_val(k)[15:8]);
        end
    endtask

    function automatic logic ready_pat(int md, int c);
        if (md == 0) return 1'b1;
        if (md == 1) return c[0];
        return (c % 5 != 0) && (c % 7 != 3);
    endfunction

    // monitor and reference comparison, every negative edge
    always @(negedge clk) begin
        logic rdy;
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL R8 watchdog: dumps %0d expected 3", dumps_done);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
        if (rst_n) begin
            if (prev_stall)
                check(out_valid && out_data == prev_data, "R9 hold under stall",
                      int'(out_data), int'(prev_data));
            if (pr_rd)
                check(m_impl(int'(pr_mod), int'(pr_idx)) && !m_prot(int'(pr_mod), int'(pr_idx))
                      && !prev_rd, "R6 read strobe", int'({pr_mod, pr_idx}), 0);
            prev_rd = pr_rd;
            if (done) begin
                check(exp_q.size() == 0 && bytes_seen == 413, "R8 byte total at done",
                      bytes_seen, 413);
                dumps_done++;
            end
            rdy = ready_pat(mode, cyc);
            out_ready = rdy;
            if (out_valid && rdy) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10 extra byte", int'(out_data), 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(out_data == e, "R3 byte stream", int'(out_data), int'(e));
                end
                bytes_seen++;
            end
            prev_stall = out_valid && !rdy;
            prev_data  = out_data;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check(!out_valid && !busy && !done && !pr_rd, "R1 reset state",
              int'({out_valid, busy, done, pr_rd}), 0);
        rst_n = 1'b1;
        for (int md = 0; md < 3; md++) begin
            int target;
            target = dumps_done + 1;
            @(negedge clk);
            mode = md;
            bytes_seen = 0;
            build_expected();
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(busy, "R8 busy after start", int'(busy), 1);
            if (md == 1) begin
                repeat (60) @(negedge clk);
                start = 1'b1; // R10: ignored while busy
                @(negedge clk);
                start = 1'b0;
            end
            while (dumps_done < target) @(negedge clk);
            @(negedge clk);
            check(!busy && !done, "R8 idle after done", int'({busy, done}), 0);
        end
        repeat (5) @(negedge clk);
        check(!out_valid && exp_q.size() == 0, "R10 no restart", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule